// File: doc/BRIEF.md
# Compressed Parcel Expander (10-bit mode)

This block takes one 16-bit instruction parcel from a stream that is known to be in the 10-bit compressed mode. It turns the parcel into a wide operation descriptor that later pipeline stages can use without knowing the compressed format. The descriptor holds:

- an operation code;
- destination and source register numbers;
- an immediate or byte branch displacement;
- condition-register field and bit selectors;
- a link flag and a record flag;
- condition-test enable and invert flags;
- separate illegal and no-operation flags.

Decoding is purely combinational. The descriptor is captured in a single output register, and a valid/ready handshake sits on both sides of that register. The input is accepted whenever the register is empty or is being drained in the same cycle.

The compressed set reuses register-zero encodings for other operations:

- subtract with a zero first operand becomes negate;
- nor becomes not;
- add becomes a bank-select.

Most destinations are implied: the destination is the same register as the second source. Any sub-encoding that is not assigned in this mode raises the illegal flag, and every other descriptor field is then zero.

Top module: `cxp_expand`

## Requirements
- R1: Parcel fields use LSB-0 numbering.
  - Group: `parcel[10:8]`.
  - Variant: `parcel[7]`.
  - Field X: `parcel[6:4]`.
  - Field Y: `parcel[3:1]`.
  - Mode bit: `parcel[0]`.

  `parcel[15:11]` has no effect on any output. The mode bit matters only for group 0 with a zero offset.
- R2: `out_op` uses these codes: 0 none, 1 branch, 2 branch-to-link, 3 load, 4 store, 5 float load, 6 float store, 7 move-CR-field, 8 bank-select, 9 add, 10 multiply, 11 subtract, 12 negate, 13 and, 14 nand, 15 or, 16 nor, 17 not, 18 float add, 19 float subtract, 20 float negate, 21 float multiply. Any descriptor field that a requirement does not name is zero.
- R3: Group 0 with a nonzero offset `parcel[6:1]` is a branch.
  - `out_link` = `parcel[7]`.
  - `out_imm` = the offset sign-extended and multiplied by 2.
- R4: Group 0 with a zero offset has no branch.
  - Mode bit 0 and variant 1: `out_nop`=1.
  - Mode bit 0 and variant 0: illegal.
  - Mode bit 1: illegal.
- R5: Group 1 variant 0 is branch-to-link.
  - `out_link` = `parcel[6]`.
  - `out_crbit` = `parcel[5:4]`.
  - `out_cond_en` = `parcel[3]`.
  - `out_cond_inv` = `parcel[2]`.
  - `out_crf` = 0.
- R6: Group 1 variant 1:
  - With `parcel[6]`=1 it is a float load (`parcel[3]`=0) or a float store (`parcel[3]`=1).
    - `out_ra` = `{0,parcel[5:4]}`.
    - `out_rb` = `{0,parcel[2:1]}`.
    - A float load also sets `out_rd` = `out_rb`.
  - With `parcel[6]`=0 it is move-CR-field.
    - `out_crf` = `{0,parcel[5:4]}`.
    - `out_ra` = source field `parcel[3:1]`.
- R7: Group 2 variant 0 with Y≠0 is add, with `out_rd`=`out_rb`=X and `out_ra`=Y. With Y=0 it is bank-select, with `out_imm` = X zero-extended. Group 2 variant 1 is multiply, with the same register mapping as add, for any Y.
- R8: Group 3 variant 0 records to CR0 (`out_rec`=1, `out_crf`=0).
  - Y≠0: subtract (`out_rd`=`out_rb`=X, `out_ra`=Y).
  - Y=0: negate (`out_ra`=0).
- R9: Groups 4 and 5 with Y≠0 are and, nand, or and nor, selected by `{parcel[8],parcel[7]}` = 00, 01, 10, 11 respectively, with X/Y mapped as for add. With Y=0, group 5 variant 1 is not (`out_rd`=`out_rb`=X) and the other three are illegal.
- R10: Group 3 variant 1 is float subtract (Y≠0) or float negate (Y=0), with `out_rec`=1 and `out_crf`=1. Group 6 is float add (variant 0) or float multiply (variant 1) when Y≠0, with `out_rec`=0. Group 6 with Y=0 is illegal.
- R11: Group 7 is illegal if `parcel[6]` or `parcel[3]` is 1. Otherwise:
  - Variant 0 is a load: `out_rd`=`out_rb`=`{0,parcel[2:1]}`, `out_ra`=`{0,parcel[5:4]}`.
  - Variant 1 is a store with zero offset: `out_ra`=`{0,parcel[5:4]}`, data register `out_rb`=`{0,parcel[2:1]}`.
- R12: An illegal descriptor has `out_illegal`=1, `out_op`=0, `out_nop`=0, and every other field zero.
- R13: Handshake on the output register.
  - `in_ready` is 0 during reset and until the reset release has been synchronised. After that, `in_ready` = `!out_valid || out_ready`.
  - An accepted parcel's descriptor is valid from the edge that accepts it.
  - While `out_valid && !out_ready`, the descriptor is held unchanged.
  - Reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Parcel offered |
| in_ready | output | 1 | Parcel can be taken |
| parcel | input | 16 | Compressed instruction parcel |
| out_valid | output | 1 | Descriptor held |
| out_ready | input | 1 | Consumer takes descriptor |
| out_op | output | 5 | Operation code (R2) |
| out_rd | output | 3 | Destination register |
| out_ra | output | 3 | First source / base / CR source field |
| out_rb | output | 3 | Second source / store data register |
| out_imm | output | IMM_W | Immediate, bank or byte displacement |
| out_crf | output | 3 | CR field selector |
| out_crbit | output | 2 | Bit within CR0 for branch-to-link |
| out_link | output | 1 | Write link register |
| out_rec | output | 1 | Record result to CR field |
| out_cond_en | output | 1 | Condition test enabled |
| out_cond_inv | output | 1 | Condition test inverted |
| out_illegal | output | 1 | Parcel is illegal |
| out_nop | output | 1 | Parcel is a no-operation |

## Verification
A descriptor is due one clock edge after the edge that accepts its parcel. It stays on the outputs for as many cycles as `out_ready` is held low. The bench drives inputs shortly after each rising edge and samples on the falling edge. A parcel counts as accepted only when `in_ready` is high at that falling edge, and only then is its expected descriptor queued. A descriptor is compared only at a falling edge where `out_valid` and `out_ready` are both high, so each queued item matches exactly one transfer. The bench sweeps every one of the 65536 parcels, inserts a stall on the output roughly one cycle in five, and checks that stalled descriptors do not change.

// File: rtl/cxp_pkg.sv
package cxp_pkg;
  localparam int REG_W = 3;
  localparam int OP_W  = 5;
  localparam int OFF_W = 6;
  localparam int CRF_W = 3;
  localparam int CRB_W = 2;
  localparam int FLAG_N = 6;

  typedef enum logic [OP_W-1:0] {
    OP_NONE  = 5'd0,
    OP_B     = 5'd1,
    OP_BCLR  = 5'd2,
    OP_LD    = 5'd3,
    OP_ST    = 5'd4,
    OP_FLD   = 5'd5,
    OP_FST   = 5'd6,
    OP_MCRF  = 5'd7,
    OP_CBANK = 5'd8,
    OP_ADD   = 5'd9,
    OP_MUL   = 5'd10,
    OP_SUB   = 5'd11,
    OP_NEG   = 5'd12,
    OP_AND   = 5'd13,
    OP_NAND  = 5'd14,
    OP_OR    = 5'd15,
    OP_NOR   = 5'd16,
    OP_NOT   = 5'd17,
    OP_FADD  = 5'd18,
    OP_FSUB  = 5'd19,
    OP_FNEG  = 5'd20,
    OP_FMUL  = 5'd21
  } cxp_op_e;
endpackage

// File: rtl/cxp_offset.sv
module cxp_offset #(
  parameter int FIELD_W = 6,
  parameter int IMM_W   = 16
) (
  input  logic [FIELD_W-1:0] off_field,
  output logic [IMM_W-1:0]   byte_disp
);
  localparam int PAD_W = IMM_W - FIELD_W - 1;

  // signed 2-byte units to byte displacement
  assign byte_disp = {{PAD_W{off_field[FIELD_W-1]}}, off_field, 1'b0};
endmodule

// File: rtl/cxp_decode.sv
module cxp_decode
  import cxp_pkg::*;
#(
  parameter int IMM_W = 16
) (
  input  logic [10:0]       pcl,
  input  logic [IMM_W-1:0]  br_disp,
  output cxp_op_e           op,
  output logic [REG_W-1:0]  rd,
  output logic [REG_W-1:0]  ra,
  output logic [REG_W-1:0]  rb,
  output logic [IMM_W-1:0]  imm,
  output logic [CRF_W-1:0]  crf,
  output logic [CRB_W-1:0]  crbit,
  output logic              link,
  output logic              rec,
  output logic              cond_en,
  output logic              cond_inv,
  output logic              illegal,
  output logic              nop
);
  logic [2:0]       grp;
  logic             var_b;
  logic [REG_W-1:0] fx;
  logic [REG_W-1:0] fy;
  logic             mbit;
  logic             y_zero;

  assign grp    = pcl[10:8];
  assign var_b  = pcl[7];
  assign fx     = pcl[6:4];
  assign fy     = pcl[3:1];
  assign mbit   = pcl[0];
  assign y_zero = (fy == '0);

  always_comb begin
    op       = OP_NONE;
    rd       = '0;
    ra       = '0;
    rb       = '0;
    imm      = '0;
    crf      = '0;
    crbit    = '0;
    link     = 1'b0;
    rec      = 1'b0;
    cond_en  = 1'b0;
    cond_inv = 1'b0;
    illegal  = 1'b0;
    nop      = 1'b0;
    case (grp)
      3'd0: begin
        if (pcl[6:1] != '0) begin
          op   = OP_B;
          link = var_b;
          imm  = br_disp;
        end else if (!mbit && var_b) begin
          nop = 1'b1;
        end else begin
          illegal = 1'b1;
        end
      end
      3'd1: begin
        if (!var_b) begin
          op       = OP_BCLR;
          link     = fx[2];
          crbit    = fx[1:0];
          cond_en  = fy[2];
          cond_inv = fy[1];
        end else if (fx[2]) begin
          ra = {1'b0, fx[1:0]};
          rb = {1'b0, fy[1:0]};
          if (!fy[2]) begin
            op = OP_FLD;
            rd = {1'b0, fy[1:0]};
          end else begin
            op = OP_FST;
          end
        end else begin
          op  = OP_MCRF;
          crf = {1'b0, fx[1:0]};
          ra  = fy;
        end
      end
      3'd2: begin
        if (var_b || !y_zero) begin
          op = var_b ? OP_MUL : OP_ADD;
          rd = fx;
          rb = fx;
          ra = fy;
        end else begin
          op  = OP_CBANK;
          imm = {{(IMM_W-REG_W){1'b0}}, fx};
        end
      end
      3'd3: begin
        rec = 1'b1;
        crf = {2'b00, var_b};
        rd  = fx;
        rb  = fx;
        ra  = fy;
        if (var_b) op = y_zero ? OP_FNEG : OP_FSUB;
        else       op = y_zero ? OP_NEG  : OP_SUB;
      end
      3'd4, 3'd5: begin
        if (!y_zero) begin
          rd = fx;
          rb = fx;
          ra = fy;
          case ({grp[0], var_b})
            2'b00:   op = OP_AND;
            2'b01:   op = OP_NAND;
            2'b10:   op = OP_OR;
            default: op = OP_NOR;
          endcase
        end else if (grp[0] && var_b) begin
          op = OP_NOT;
          rd = fx;
          rb = fx;
        end else begin
          illegal = 1'b1;
        end
      end
      3'd6: begin
        if (!y_zero) begin
          op = var_b ? OP_FMUL : OP_FADD;
          rd = fx;
          rb = fx;
          ra = fy;
        end else begin
          illegal = 1'b1;
        end
      end
      default: begin
        if (fx[2] || fy[2]) begin
          illegal = 1'b1;
        end else begin
          ra = {1'b0, fx[1:0]};
          rb = {1'b0, fy[1:0]};
          if (!var_b) begin
            op = OP_LD;
            rd = {1'b0, fy[1:0]};
          end else begin
            op = OP_ST;
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/cxp_stage.sv
module cxp_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic [1:0]   sync_q;
  logic         run;
  logic         load_en;
  logic         valid_d;
  logic         valid_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign run = sync_q[1];

  assign in_ready = run && (!valid_q || out_ready);
  assign load_en  = in_valid && in_ready;

  always_comb begin
    valid_d = valid_q;
    if (load_en)        valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (load_en) data_q <= in_data;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
endmodule

// File: rtl/cxp_expand.sv
module cxp_expand
  import cxp_pkg::*;
#(
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [15:0]      parcel,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [4:0]       out_op,
  output logic [2:0]       out_rd,
  output logic [2:0]       out_ra,
  output logic [2:0]       out_rb,
  output logic [IMM_W-1:0] out_imm,
  output logic [2:0]       out_crf,
  output logic [1:0]       out_crbit,
  output logic             out_link,
  output logic             out_rec,
  output logic             out_cond_en,
  output logic             out_cond_inv,
  output logic             out_illegal,
  output logic             out_nop
);
  localparam int DESC_W = OP_W + 3*REG_W + IMM_W + CRF_W + CRB_W + FLAG_N;

  logic [IMM_W-1:0]  br_disp;
  cxp_op_e           d_op;
  logic [REG_W-1:0]  d_rd, d_ra, d_rb;
  logic [IMM_W-1:0]  d_imm;
  logic [CRF_W-1:0]  d_crf;
  logic [CRB_W-1:0]  d_crbit;
  logic              d_link, d_rec, d_cen, d_cinv, d_ill, d_nop;
  logic [DESC_W-1:0] desc_d;
  logic [DESC_W-1:0] desc_q;
  logic              unused_hi;

  // upper five parcel bits belong to the other encoding mode
  assign unused_hi = ^parcel[15:11];

  cxp_offset #(.FIELD_W(OFF_W), .IMM_W(IMM_W)) u_off (
    .off_field (parcel[6:1]),
    .byte_disp (br_disp)
  );

  cxp_decode #(.IMM_W(IMM_W)) u_dec (
    .pcl      (parcel[10:0]),
    .br_disp  (br_disp),
    .op       (d_op),
    .rd       (d_rd),
    .ra       (d_ra),
    .rb       (d_rb),
    .imm      (d_imm),
    .crf      (d_crf),
    .crbit    (d_crbit),
    .link     (d_link),
    .rec      (d_rec),
    .cond_en  (d_cen),
    .cond_inv (d_cinv),
    .illegal  (d_ill),
    .nop      (d_nop)
  );

  assign desc_d = {d_op, d_rd, d_ra, d_rb, d_imm, d_crf, d_crbit,
                   d_link, d_rec, d_cen, d_cinv, d_ill, d_nop};

  cxp_stage #(.W(DESC_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (desc_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (desc_q)
  );

  assign {out_op, out_rd, out_ra, out_rb, out_imm, out_crf, out_crbit,
          out_link, out_rec, out_cond_en, out_cond_inv, out_illegal, out_nop} = desc_q;
endmodule

// File: rtl/cxp_expand_chk.sv
module cxp_expand_chk #(
  parameter int IMM_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [4:0]       out_op,
  input logic [2:0]       out_rd,
  input logic [2:0]       out_ra,
  input logic [2:0]       out_rb,
  input logic [IMM_W-1:0] out_imm,
  input logic [2:0]       out_crf,
  input logic             out_rec,
  input logic             out_illegal,
  input logic             out_nop
);
  // R13
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R13
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_op) && $stable(out_rd)
      && $stable(out_ra) && $stable(out_rb) && $stable(out_imm) && $stable(out_illegal)));

  // R12
  illegal_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_op == 5'd0 && !out_nop && out_imm == '0
      && out_rd == 3'd0 && out_ra == 3'd0 && out_rb == 3'd0 && out_crf == 3'd0));

  // R4
  nop_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_illegal && out_nop));

  // R3
  branch_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_op == 5'd1) |-> (out_imm[0] == 1'b0 && out_imm != '0));

  // R8
  int_record_cr0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_op == 5'd11 || out_op == 5'd12)) |-> (out_rec && out_crf == 3'd0));

  // R10
  fp_record_cr1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_op == 5'd19 || out_op == 5'd20)) |-> (out_rec && out_crf == 3'd1));
endmodule

bind cxp_expand cxp_expand_chk #(.IMM_W(IMM_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_op      (out_op),
  .out_rd      (out_rd),
  .out_ra      (out_ra),
  .out_rb      (out_rb),
  .out_imm     (out_imm),
  .out_crf     (out_crf),
  .out_rec     (out_rec),
  .out_illegal (out_illegal),
  .out_nop     (out_nop)
);

// File: tb/cxp_expand_test.sv
`timescale 1ns/1ps
module cxp_expand_test;
  localparam int N_PARCEL = 65536;
  localparam int WD_LIMIT = 190000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] parcel;
  logic        out_valid;
  logic        out_ready;
  logic [4:0]  out_op;
  logic [2:0]  out_rd, out_ra, out_rb, out_crf;
  logic [15:0] out_imm;
  logic [1:0]  out_crbit;
  logic        out_link, out_rec, out_cond_en, out_cond_inv, out_illegal, out_nop;

  int errors = 0;
  int checks = 0;
  int rx_count = 0;
  logic [40:0] exp_q[$];
  logic [15:0] pcl_q[$];

  always #2 clk = ~clk;

  cxp_expand uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .parcel(parcel), .out_valid(out_valid), .out_ready(out_ready),
    .out_op(out_op), .out_rd(out_rd), .out_ra(out_ra), .out_rb(out_rb),
    .out_imm(out_imm), .out_crf(out_crf), .out_crbit(out_crbit),
    .out_link(out_link), .out_rec(out_rec), .out_cond_en(out_cond_en),
    .out_cond_inv(out_cond_inv), .out_illegal(out_illegal), .out_nop(out_nop)
  );

  // reference model written from the requirement text
  function automatic logic [40:0] ref_desc(input logic [15:0] p);
    int op = 0, rd = 0, ra = 0, rb = 0, imm = 0, crf = 0, crb = 0;
    bit lk = 0, rc = 0, ce = 0, ci = 0, il = 0, np = 0;
    int g = int'(p[10:8]);
    bit v = p[7];
    int x = int'(p[6:4]);
    int y = int'(p[3:1]);
    if (g == 0) begin
      int o = int'(p[6:1]);
      if (o != 0) begin
        if (o > 31) o = o - 64;
        op = 1; lk = v; imm = o * 2;
      end else if (p[0] == 1'b0 && v) np = 1;
      else il = 1;
    end else if (g == 1 && !v) begin
      op = 2; lk = p[6]; crb = int'(p[5:4]); ce = p[3]; ci = p[2];
    end else if (g == 1) begin
      if (p[6]) begin
        ra = int'(p[5:4]); rb = int'(p[2:1]);
        if (p[3]) op = 6;
        else begin op = 5; rd = rb; end
      end else begin
        op = 7; crf = int'(p[5:4]); ra = y;
      end
    end else if (g == 2) begin
      if (!v && y == 0) begin op = 8; imm = x; end
      else begin op = v ? 10 : 9; rd = x; rb = x; ra = y; end
    end else if (g == 3) begin
      rc = 1; crf = v ? 1 : 0; rd = x; rb = x; ra = y;
      if (v) op = (y == 0) ? 20 : 19;
      else   op = (y == 0) ? 12 : 11;
    end else if (g == 4 || g == 5) begin
      if (y != 0) begin
        op = 13 + (g - 4) * 2 + int'(v); rd = x; rb = x; ra = y;
      end else if (g == 5 && v) begin
        op = 17; rd = x; rb = x;
      end else il = 1;
    end else if (g == 6) begin
      if (y != 0) begin op = v ? 21 : 18; rd = x; rb = x; ra = y; end
      else il = 1;
    end else begin
      if (p[6] || p[3]) il = 1;
      else begin
        ra = int'(p[5:4]); rb = int'(p[2:1]);
        if (v) op = 4;
        else begin op = 3; rd = rb; end
      end
    end
    return {5'(op), 3'(rd), 3'(ra), 3'(rb), 16'(imm), 3'(crf), 2'(crb),
            lk, rc, ce, ci, il, np};
  endfunction

  function automatic string req_tag(input logic [15:0] p, input logic [40:0] e);
    string t;
    int g = int'(p[10:8]);
    if (g == 0)      t = (p[6:1] != 0) ? "R3" : "R4";
    else if (g == 1) t = p[7] ? "R6" : "R5";
    else if (g == 2) t = "R7";
    else if (g == 3) t = p[7] ? "R10" : "R8";
    else if (g == 6) t = "R10";
    else if (g == 7) t = "R11";
    else             t = "R9";
    if (e[1]) t = {t, " R12"};
    if (p[15:11] != 0) t = {t, " R1"};
    return {t, " R2"};
  endfunction

  task automatic send(input logic [15:0] p);
    @(posedge clk); #1;
    in_valid = 1'b1;
    parcel   = p;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    exp_q.push_back(ref_desc(p));
    pcl_q.push_back(p);
  endtask

  task automatic idle_cycle();
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: drives out_ready, compares transfers and stalled holds
  initial begin : monitor
    int cyc = 0;
    logic        held = 1'b0;
    logic [40:0] held_v = '0;
    out_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      out_ready = (cyc % 5) != 3;
      @(negedge clk);
      if (rst_n) begin
        logic [40:0] act;
        act = {out_op, out_rd, out_ra, out_rb, out_imm, out_crf, out_crbit,
               out_link, out_rec, out_cond_en, out_cond_inv, out_illegal, out_nop};
        if (held && out_valid) begin
          checks++;
          if (act !== held_v) begin
            errors++;
            $display("FAIL R13 stalled descriptor changed: got=%h exp=%h", act, held_v);
          end
        end
        held = 1'b0;
        if (out_valid && !out_ready) begin
          held = 1'b1;
          held_v = act;
        end
        if (out_valid && out_ready) begin
          checks++;
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R13 unexpected descriptor: got=%h exp=none", act);
          end else begin
            logic [40:0] e;
            logic [15:0] p;
            e = exp_q.pop_front();
            p = pcl_q.pop_front();
            rx_count++;
            if (act !== e) begin
              errors++;
              $display("FAIL %s parcel=%h got=%h exp=%h", req_tag(p, e), p, act, e);
            end
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (WD_LIMIT) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R13 watchdog: received=%0d expected=%0d", rx_count, N_PARCEL);
    finish_run();
  end

  initial begin : driver
    rst_n    = 1'b0;
    in_valid = 1'b0;
    parcel   = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R13: reset state
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b0) begin
      errors++;
      $display("FAIL R13 reset state: out_valid=%b in_ready=%b exp=0 0", out_valid, in_ready);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R13: ready once reset release is synchronised and register empty
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R13 after release: out_valid=%b in_ready=%b exp=0 1", out_valid, in_ready);
    end
    for (int i = 0; i < N_PARCEL; i++) begin
      send(16'(i));
      if ((i % 13) == 12) idle_cycle();
    end
    idle_cycle();
    wait (rx_count == N_PARCEL);
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R13: every accepted parcel produced exactly one descriptor
    checks++;
    if (exp_q.size() != 0 || out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R13 drain: pending=%0d out_valid=%b exp=0 0", exp_q.size(), out_valid);
    end
    finish_run();
  end
endmodule